// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an asynchronous byte-wide static RAM. The host offers one request at a time on a valid/ready handshake: an address, write data and a direction flag. The sequencer turns each accepted request into a timed episode on the memory's active-low chip-select, output-enable and write-strobe pins, together with the address and data bus. Each read result comes back to the host on a one-cycle strobe with the captured byte.

Every phase length is a whole number of system clock cycles. Each count is derived at elaboration from a nanosecond (picosecond) minimum and the configured clock period, and is rounded up. The counts cover the read access time, the write strobe width (the largest of the strobe pulse, data setup and address setup minimums), a power-up wait and a read-to-write bus turnaround. The output enable is kept high during every write, so the memory never drives the bus while the sequencer does. No request is taken until the power-up wait has run out.

Top module: `asram_ctl`

## Requirements
- R1: While reset is high and in the cycle after it, sram_ce_n, sram_oe_n and sram_we_n are 1, sram_dq_oe is 0, req_ready is 0 and rsp_valid is 0.
- R2: After reset is released, req_ready stays 0 for at least PU_CYC = ceil(POWERUP_PS/CLK_PS) clock cycles and then rises to 1.
- R3: A read (request with req_write = 0) holds sram_ce_n = 0, sram_oe_n = 0 and sram_we_n = 1 for exactly RD_CYC = max(1, ceil(T_RC_PS/CLK_PS)) cycles. The byte on sram_dq_i is captured at the end of that window and presented on rsp_rdata while rsp_valid is 1 for exactly one cycle.
- R4: A write (req_write = 1) holds sram_ce_n = 0, sram_we_n = 0, sram_oe_n = 1 and sram_dq_oe = 1 for exactly WE_CYC cycles. WE_CYC is the largest of ceil(T_PWE_PS/CLK_PS), ceil(T_SD_PS/CLK_PS) and ceil(T_AW_PS/CLK_PS), at least 1. sram_dq_o carries the request's data, unchanged, for the whole strobe.
- R5: sram_dq_oe is never 1 while sram_oe_n is 0, nor in the cycle after one with sram_oe_n = 0. When a write follows a read, at least TURN_CYC + 1 cycles pass with sram_oe_n = 1 and sram_dq_oe = 0 between the end of the read and the start of the write.
- R6: req_ready is 0 while an access is in progress and the chip select is high whenever req_ready is 1. A request held while req_ready is 0 is taken only once, and every accepted request produces exactly one chip-select episode.
- R7: A read result strobe and the acceptance of the next request may fall in the same cycle. A read issued in that cycle starts at that clock edge.
- R8: sram_addr does not change during a chip-select episode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Sequencer takes the request at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle strobe: read result valid |
| rsp_rdata | output | DATA_W | Captured read byte |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_addr | output | ADDR_W | Memory address |
| sram_dq_o | output | DATA_W | Data driven toward the memory |
| sram_dq_oe | output | 1 | 1 = drive sram_dq_o onto the shared bus |
| sram_dq_i | input | DATA_W | Data read back from the shared bus |

## Verification
The read-result strobe and the handshake that admits the next request share a cycle. The bench provokes this by issuing reads back to back, with the next request already waiting when the previous read completes. It counts cycles in which rsp_valid, req_valid and req_ready are all high, and the scoreboard confirms that both reads return the right bytes in order. A read followed at once by a write makes the turnaround logic and the write launch meet. There the bench measures the released-bus gap and watches the bus for overlap every cycle.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WR
  } asram_state_e;

  // Whole clock cycles covering a picosecond minimum, never less than one.
  function automatic int cycles_for(input int min_ps, input int clk_ps);
    int c;
    c = (min_ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/asram_powerup.sv
`timescale 1ns/1ps
module asram_powerup #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt == CW'(CYCLES - 1)) done <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/asram_timer.sv
`timescale 1ns/1ps
module asram_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/asram_ctl.sv
`timescale 1ns/1ps
module asram_ctl #(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int CLK_PS     = 20000,
  parameter int T_RC_PS    = 10000,
  parameter int T_PWE_PS   = 7000,
  parameter int T_SD_PS    = 5000,
  parameter int T_AW_PS    = 7000,
  parameter int POWERUP_PS = 100_000_000,
  parameter int TURN_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);
  import asram_pkg::*;

  localparam int RD_CYC  = cycles_for(T_RC_PS, CLK_PS);
  localparam int WE_CYC  = max3(cycles_for(T_PWE_PS, CLK_PS),
                                cycles_for(T_SD_PS, CLK_PS),
                                cycles_for(T_AW_PS, CLK_PS));
  localparam int PU_CYC  = cycles_for(POWERUP_PS, CLK_PS);
  localparam int TA_CYC  = (TURN_CYC < 1) ? 1 : TURN_CYC;
  localparam int MAX_CNT = max3(RD_CYC, WE_CYC, TA_CYC);
  localparam int TMR_W   = $clog2(MAX_CNT + 1);

  asram_state_e      state;
  logic              pu_done;
  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_zero;
  logic              last_rd;
  logic              take;

  asram_powerup #(.CYCLES(PU_CYC)) u_pwr (
    .clk  (clk),
    .rst  (rst),
    .done (pu_done)
  );

  asram_timer #(.W(TMR_W)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .val  (tmr_val),
    .zero (tmr_zero)
  );

  assign take = (state == ST_IDLE) && req_ready && req_valid;

  // Timer reload: each phase starts with (length - 1) so it ends after length edges.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (take) begin
      tmr_load = 1'b1;
      if (!req_write)   tmr_val = TMR_W'(RD_CYC - 1);
      else if (last_rd) tmr_val = TMR_W'(TA_CYC - 1);
      else              tmr_val = TMR_W'(WE_CYC - 1);
    end else if (state == ST_TURN && tmr_zero) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(WE_CYC - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_PWRUP;
      req_ready  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      sram_ce_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_addr  <= '0;
      sram_dq_o  <= '0;
      sram_dq_oe <= 1'b0;
      last_rd    <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_PWRUP: begin
          if (pu_done) begin
            state     <= ST_IDLE;
            req_ready <= 1'b1;
          end
        end
        ST_IDLE: begin
          if (take) begin
            req_ready <= 1'b0;
            sram_addr <= req_addr;
            sram_dq_o <= req_wdata;
            if (!req_write) begin
              sram_ce_n <= 1'b0;
              sram_oe_n <= 1'b0;
              state     <= ST_RD;
            end else if (last_rd) begin
              state     <= ST_TURN;
            end else begin
              sram_ce_n  <= 1'b0;
              sram_we_n  <= 1'b0;
              sram_dq_oe <= 1'b1;
              state      <= ST_WR;
            end
          end
        end
        ST_RD: begin
          if (tmr_zero) begin
            rsp_rdata <= sram_dq_i;
            rsp_valid <= 1'b1;
            sram_ce_n <= 1'b1;
            sram_oe_n <= 1'b1;
            req_ready <= 1'b1;
            last_rd   <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_TURN: begin
          if (tmr_zero) begin
            sram_ce_n  <= 1'b0;
            sram_we_n  <= 1'b0;
            sram_dq_oe <= 1'b1;
            state      <= ST_WR;
          end
        end
        ST_WR: begin
          if (tmr_zero) begin
            sram_ce_n  <= 1'b1;
            sram_we_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
            req_ready  <= 1'b1;
            last_rd    <= 1'b0;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_PWRUP;
      endcase
    end
  end
endmodule

// File: rtl/asram_ctl_chk.sv
`timescale 1ns/1ps
module asram_ctl_chk #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          dq_oe,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] dq_o,
  input logic          pu_done
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (ce_n && oe_n && we_n && !dq_oe && !req_ready && !rsp_valid));

  a_r2_wait_powerup: assert property (@(posedge clk) disable iff (rst)
    !pu_done |-> !req_ready);

  a_r3_rsp_single: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r4_oe_off_in_write: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (oe_n && !ce_n && dq_oe));

  a_r4_data_steady: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_o));

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> oe_n);

  a_r5_release_gap: assert property (@(posedge clk) disable iff (rst)
    !oe_n |=> !dq_oe);

  a_r6_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> ce_n);

  a_r8_addr_steady: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && $past(!ce_n)) |-> $stable(addr));
endmodule

bind asram_ctl asram_ctl_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .ce_n      (sram_ce_n),
  .oe_n      (sram_oe_n),
  .we_n      (sram_we_n),
  .dq_oe     (sram_dq_oe),
  .addr      (sram_addr),
  .dq_o      (sram_dq_o),
  .pu_done   (pu_done)
);

// File: tb/sim_asram_ctl.sv
`timescale 1ns/1ps
module sim_asram_ctl;
  localparam int AW     = 8;
  localparam int DW     = 8;
  localparam int EXP_RD = 2;     // ceil(30000/20000)
  localparam int EXP_WE = 3;     // ceil(45000/20000)
  localparam int EXP_PU = 5000;  // 100 us at 20 ns
  localparam int TURN   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [DW-1:0] rsp_rdata, sram_dq_o, sram_dq_i;
  logic [AW-1:0] sram_addr;

  always #10 clk = ~clk;

  asram_ctl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_PS(20000), .T_RC_PS(30000),
    .T_PWE_PS(45000), .T_SD_PS(5000), .T_AW_PS(7000),
    .POWERUP_PS(100_000_000), .TURN_CYC(TURN)
  ) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_addr(sram_addr),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  // Memory model
  logic [DW-1:0] mem [256];
  logic [DW-1:0] shadow [256];
  assign sram_dq_i = (!sram_ce_n && !sram_oe_n && sram_we_n) ? mem[sram_addr] : 'x;

  int checks = 0, fails = 0;
  int n_issued = 0, n_access = 0, n_reads = 0, n_rsp = 0, n_overlap = 0;
  logic [DW-1:0] expq [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: called at a falling edge, returns at a falling edge after acceptance.
  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n_issued++;
    if (w) shadow[a] = d;
    else begin expq.push_back(shadow[a]); n_reads++; end
  endtask

  // Monitor and scoreboard
  logic prev_ce = 1'b1, prev_we = 1'b1, prev_rd = 1'b0, last_was_rd = 1'b0, prev_dqoe = 1'b0;
  int rd_run = 0, we_run = 0, gap = 0;
  logic [AW-1:0] w_addr;
  logic [DW-1:0] w_data;

  always @(negedge clk) begin
    if (!rst) begin
      logic rd_now;
      rd_now = !sram_ce_n && !sram_oe_n;
      if (!sram_ce_n && prev_ce) n_access++;
      chk(!(sram_dq_oe && !sram_oe_n), "R5 bus overlap", sram_dq_oe, 0);
      if (rd_now) rd_run++;
      if (!rd_now && prev_rd) begin
        chk(rd_run == EXP_RD, "R3 read window", rd_run, EXP_RD);
        rd_run = 0; last_was_rd = 1'b1; gap = 0;
      end
      if (sram_oe_n && !sram_dq_oe) gap++;
      if (sram_dq_oe && !prev_dqoe) begin
        if (last_was_rd) chk(gap >= TURN + 1, "R5 turnaround gap", gap, TURN + 1);
        last_was_rd = 1'b0;
      end
      if (!sram_we_n) begin
        chk(sram_oe_n && sram_dq_oe, "R4 write strobes", {sram_oe_n, sram_dq_oe}, 3);
        if (prev_we) begin w_addr = sram_addr; w_data = sram_dq_o; end
        else chk(sram_dq_o == w_data, "R4 data steady", sram_dq_o, w_data);
        we_run++;
      end else if (!prev_we) begin
        chk(we_run == EXP_WE, "R4 strobe width", we_run, EXP_WE);
        mem[w_addr] = w_data;
        we_run = 0;
      end
      if (rsp_valid) begin
        logic [DW-1:0] e;
        n_rsp++;
        if (req_valid && req_ready) n_overlap++;
        if (expq.size() == 0) chk(0, "R3 unexpected response", rsp_rdata, 0);
        else begin
          e = expq.pop_front();
          chk(rsp_rdata === e, "R3 read data", rsp_rdata, e);
        end
      end
      prev_ce = sram_ce_n; prev_we = sram_we_n; prev_rd = rd_now; prev_dqoe = sram_dq_oe;
    end
  end

  bit finished = 1'b0;

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int lowcnt;
    for (int i = 0; i < 256; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && !req_ready && !rsp_valid,
        "R1 reset outputs", {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, req_ready, rsp_valid}, 6'b111000);
    rst = 1'b0;
    // R2: power-up wait, request already offered and must be ignored
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h10; req_wdata = 8'h77;
    lowcnt = 0;
    while (!req_ready && lowcnt < 6000) begin
      chk(sram_ce_n, "R6 no access before ready", sram_ce_n, 1);
      @(negedge clk); lowcnt++;
    end
    chk(lowcnt >= EXP_PU, "R2 power-up wait length", lowcnt, EXP_PU);
    chk(req_ready, "R2 ready after wait", req_ready, 1);
    req_valid = 1'b0;
    // Writes: patterns and edge addresses, write after write
    issue(1, 8'h00, 8'h00);
    issue(1, 8'hFF, 8'hFF);
    issue(1, 8'h5A, 8'hA5);
    issue(1, 8'h01, 8'h3C);
    // R6: request held while busy is taken once
    chk(!req_ready, "R6 busy after accept", req_ready, 0);
    // Reads, back to back (R7)
    issue(0, 8'h5A, 8'h00);
    issue(0, 8'hFF, 8'h00);
    issue(0, 8'h00, 8'h00);
    issue(0, 8'h01, 8'h00);
    issue(0, 8'h33, 8'h00);
    // Read then write: turnaround (R5), then read back
    issue(1, 8'h5A, 8'h96);
    issue(0, 8'h5A, 8'h00);
    issue(1, 8'h33, 8'hC3);
    issue(1, 8'h34, 8'h18);
    issue(0, 8'h33, 8'h00);
    issue(0, 8'h34, 8'h00);
    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R3 all responses returned", expq.size(), 0);
    chk(n_rsp == n_reads, "R3 response count", n_rsp, n_reads);
    chk(n_access == n_issued, "R6 one access per request", n_access, n_issued);
    chk(n_overlap > 0, "R7 response with acceptance", n_overlap, 1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule